// File: doc/BRIEF.md
# Transmit Interrupt Status Register

This block gathers five event sources of a transmit-side peripheral into one 8-bit status byte and one active-low interrupt request. The sources are a FIFO error (overflow or underflow), FIFO almost full, FIFO almost empty, an external pin event and a packet-done event. An 8-bit enable register sets the role of each bit. An enabled bit works as an interrupt: it latches on a rising edge of its source, pulls the request low, and clears when the byte is read. A bit that is not enabled is a live status flag. It shows the source level as it is now, and a read never clears it.

A host reads the byte with a single-cycle read strobe. The byte it gets back is the value from before the clear. The latched, enabled bits clear on the next clock edge, which also releases the request. Address decoding, the FIFO and the external pin setup belong to other blocks. All inputs are assumed to be synchronous to the clock.

Top module: `tx_irq_status`

## Requirements
- R1: Byte layout: bit 7 is the FIFO error, bit 6 is almost full, bit 5 is almost empty, bit 3 is the external event and bit 2 is packet done.
- R2: Bits 4, 1 and 0 always read 0, and writing an enable to them has no effect.
- R3: An enabled bit latches only on a 0-to-1 change of its source. A source that stays high does not latch again after a clear.
- R4: `irq_n` is low while at least one enabled bit is latched, and high otherwise.
- R5: In a read-strobe cycle, `rd_data` shows the value before the clear. On the next cycle, every latched enabled bit is 0 and `irq_n` is high, unless R7 applies.
- R6: A bit that is not enabled reads the present level of its source. A read does not change it, and it never drives `irq_n` low.
- R7: If an enabled source rises in the same cycle as a read strobe, that bit stays latched after the read.
- R8: Enabling a bit whose source is already high does not assert `irq_n` until the source falls and rises again.
- R9: After reset, all enables are 0, nothing is latched and `irq_n` is high.
- R10: A write to the enable register takes effect on the cycle after the write strobe. A source rise in the write cycle itself is treated under the old enable.
- R11: Clearing an enable discards that bit's latched state. The bit then reads its live level and releases `irq_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_err | input | 1 | FIFO overflow/underflow condition |
| fifo_afull | input | 1 | FIFO almost-full condition |
| fifo_aempty | input | 1 | FIFO almost-empty condition |
| ext_evt | input | 1 | External pin event |
| pkt_done | input | 1 | Packet transmitted |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write value |
| rd_stb | input | 1 | Single-cycle status read strobe |
| rd_data | output | 8 | Composed status byte |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is a read strobe that falls in the same cycle as a new rising edge on an enabled source, while a different enabled bit is already latched. The stimulus first latches the external event bit. On the next cycle it raises packet done and strobes the read together. The bench then checks that the returned byte holds only the old bit, and that afterwards only the new bit stays latched with the request still low. A second hard case is enabling a source that is already high. For this, the bench raises the sources while they are not enabled, then writes the enable. It checks that the request stays high until one source drops and rises again.

// File: rtl/txirq_pkg.sv
// Package: shared widths and bit positions of the status byte.
// Assumes an 8-bit byte with five live positions.
package txirq_pkg;
    localparam int REG_W      = 8;
    localparam int POS_ERR    = 7;
    localparam int POS_AFULL  = 6;
    localparam int POS_AEMPTY = 5;
    localparam int POS_EXT    = 3;
    localparam int POS_DONE   = 2;
    localparam logic [REG_W-1:0] LIVE_MASK =
        (REG_W'(1) << POS_ERR) | (REG_W'(1) << POS_AFULL) |
        (REG_W'(1) << POS_AEMPTY) | (REG_W'(1) << POS_EXT) |
        (REG_W'(1) << POS_DONE);
endpackage

// File: rtl/txirq_edge.sv
// Rising-edge detector, one per bit. It registers each level and flags
// a 0-to-1 change. Assumes the levels are synchronous to clk. The
// history resets to 0.
module txirq_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Keep last cycle's level of this bit.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= level_i[i];
        end
        // Flag a fresh rise of this bit.
        always_comb rise_o[i] = level_i[i] & ~prev_q[i];
    end
endmodule

// File: rtl/txirq_latch.sv
// Latch bank for enabled bits. A rise on an enabled bit sets it. A read
// clears it, but a set in the same cycle wins. A bit that is not enabled
// is held at 0, so any stale state is dropped when it is disabled.
module txirq_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise_i,
    input  logic [W-1:0] en_i,
    input  logic         rd_i,
    output logic [W-1:0] lat_o
);
    logic [W-1:0] lat_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Set on an enabled rise, clear on a read, drop when disabled.
        always_ff @(posedge clk) begin
            if (!rst_n)       lat_q[i] <= 1'b0;
            else if (!en_i[i]) lat_q[i] <= 1'b0;
            else              lat_q[i] <= rise_i[i] | (lat_q[i] & ~rd_i);
        end
    end

    assign lat_o = lat_q;

    // R5
    rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && ((rise_i & en_i) == '0)) |=> (lat_q == '0));

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_i & en_i) != '0) |=>
            ((lat_q & $past(rise_i & en_i)) == $past(rise_i & en_i)));
endmodule

// File: rtl/txirq_compose.sv
// Builds the status byte and the request. An enabled bit shows its
// latch and a disabled bit shows its live level. Reserved bits read 0.
module txirq_compose
    import txirq_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] lat_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] rd_data_o,
    output logic         irq_n_o
);
    // Pick latch or live level per bit, then mask out the reserved bits.
    always_comb begin
        for (int i = 0; i < W; i++)
            rd_data_o[i] = (en_i[i] ? lat_i[i] : level_i[i]) & LIVE_MASK[i];
    end

    // Request is active while any enabled bit is latched.
    always_comb irq_n_o = ~|(lat_i & en_i & LIVE_MASK);
endmodule

// File: rtl/tx_irq_status.sv
// Top: maskable, read-cleared interrupt status byte for a transmit path.
// Assumes all event inputs and strobes are synchronous to clk and that
// rd_stb lasts one cycle for each read.
module tx_irq_status
    import txirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_err,
    input  logic             fifo_afull,
    input  logic             fifo_aempty,
    input  logic             ext_evt,
    input  logic             pkt_done,
    input  logic             en_wr,
    input  logic [REG_W-1:0] en_wdata,
    input  logic             rd_stb,
    output logic [REG_W-1:0] rd_data,
    output logic             irq_n
);
    logic [REG_W-1:0] level;
    logic [REG_W-1:0] rise;
    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] lat;

    // Place each source at its bit position.
    always_comb begin
        level             = '0;
        level[POS_ERR]    = fifo_err;
        level[POS_AFULL]  = fifo_afull;
        level[POS_AEMPTY] = fifo_aempty;
        level[POS_EXT]    = ext_evt;
        level[POS_DONE]   = pkt_done;
    end

    // Enable register; reserved positions are not stored.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= en_wdata & LIVE_MASK;
    end

    txirq_edge #(.W(REG_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .level_i(level), .rise_o(rise)
    );

    txirq_latch #(.W(REG_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .en_i(en_q),
        .rd_i(rd_stb), .lat_o(lat)
    );

    txirq_compose #(.W(REG_W)) u_compose (
        .level_i(level), .lat_i(lat), .en_i(en_q),
        .rd_data_o(rd_data), .irq_n_o(irq_n)
    );

    // R4
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past((rise & en_q) != '0));

    // R5
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && ((rise & en_q) == '0)) |=> irq_n);

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~LIVE_MASK) == '0);
endmodule

// File: tb/tx_irq_status_bench.sv
// Bench: behavioural per-cycle model compared on every clock, plus
// directed checks on the corner cases.
module tx_irq_status_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] src = '0;   // {err, afull, aempty, ext, done}
    logic       en_wr = 1'b0;
    logic [7:0] en_wdata = '0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       irq_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    // model state
    bit m_en [8];
    bit m_lat [8];
    bit m_prev [8];

    always #2.5 clk = ~clk;

    tx_irq_status u_tx_irq_status (
        .clk(clk), .rst_n(rst_n),
        .fifo_err(src[4]), .fifo_afull(src[3]), .fifo_aempty(src[2]),
        .ext_evt(src[1]), .pkt_done(src[0]),
        .en_wr(en_wr), .en_wdata(en_wdata), .rd_stb(rd_stb),
        .rd_data(rd_data), .irq_n(irq_n)
    );

    function automatic bit live_of(int pos);
        case (pos)
            7: return src[4];
            6: return src[3];
            5: return src[2];
            3: return src[1];
            2: return src[0];
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit usable(int pos);
        return pos == 7 || pos == 6 || pos == 5 || pos == 3 || pos == 2;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] s, input logic rd, input logic ew,
                         input logic [7:0] ed);
        src = s; rd_stb = rd; en_wr = ew; en_wdata = ed;
        #1;
    endtask

    // Compare with the model, advance one clock, update the model.
    task automatic tick();
        logic [7:0] e_rd;
        bit any;
        e_rd = '0; any = 0;
        for (int i = 0; i < 8; i++) begin
            if (usable(i)) e_rd[i] = m_en[i] ? m_lat[i] : live_of(i);
            if (m_en[i] && m_lat[i]) any = 1;
        end
        chk(rd_data === e_rd, "R1 model rd_data", rd_data, e_rd);
        chk(irq_n === !any, "R4 model irq_n", {7'd0, irq_n}, {7'd0, !any});
        @(posedge clk);
        for (int i = 0; i < 8; i++) begin
            bit lv, rs;
            lv = live_of(i);
            rs = lv && !m_prev[i];
            if (!m_en[i]) m_lat[i] = 0;
            else          m_lat[i] = rs || (m_lat[i] && !rd_stb);
            m_prev[i] = lv;
            if (en_wr) m_en[i] = en_wdata[i] && usable(i);
        end
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin m_en[i] = 0; m_lat[i] = 0; m_prev[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        drive(5'b00000, 0, 0, 8'h00);
        chk(rd_data === 8'h00, "R9 reset rd_data", rd_data, 8'h00);
        chk(irq_n === 1'b1, "R9 reset irq_n", {7'd0, irq_n}, 8'h01);
        tick();
        // R1/R6 live status, all sources high, nothing enabled
        drive(5'b11111, 0, 0, 8'h00);
        chk(rd_data === 8'hEC, "R1 live byte", rd_data, 8'hEC);
        tick();
        drive(5'b11111, 1, 0, 8'h00);
        tick();
        drive(5'b11111, 0, 0, 8'h00);
        chk(rd_data === 8'hEC, "R6 read leaves live bits", rd_data, 8'hEC);
        chk(irq_n === 1'b1, "R6 no request", {7'd0, irq_n}, 8'h01);
        tick();
        // R2/R8 enable everything while sources are high
        drive(5'b11111, 0, 1, 8'hFF);
        tick();
        drive(5'b11111, 0, 0, 8'h00);
        chk(irq_n === 1'b1, "R8 no irq on enable of high source", {7'd0, irq_n}, 8'h01);
        chk((rd_data & 8'h13) === 8'h00, "R2 reserved bits", rd_data, 8'h00);
        tick();
        // R3/R4 fresh edge on done
        drive(5'b00000, 0, 0, 8'h00);
        tick();
        drive(5'b00001, 0, 0, 8'h00);
        tick();
        drive(5'b00001, 1, 0, 8'h00);
        chk(irq_n === 1'b0, "R4 irq asserted", {7'd0, irq_n}, 8'h00);
        chk(rd_data === 8'h04, "R5 pre-clear byte", rd_data, 8'h04);
        tick();
        drive(5'b00001, 0, 0, 8'h00);
        chk(rd_data === 8'h00, "R3 steady high not relatched", rd_data, 8'h00);
        chk(irq_n === 1'b1, "R5 irq released", {7'd0, irq_n}, 8'h01);
        tick();
        // R7 set during read
        drive(5'b00000, 0, 0, 8'h00);
        tick();
        drive(5'b00010, 0, 0, 8'h00);
        tick();
        drive(5'b00011, 1, 0, 8'h00);
        chk(rd_data === 8'h08, "R7 read returns old byte", rd_data, 8'h08);
        tick();
        drive(5'b00011, 0, 0, 8'h00);
        chk(rd_data === 8'h04, "R7 new bit kept", rd_data, 8'h04);
        chk(irq_n === 1'b0, "R7 irq kept", {7'd0, irq_n}, 8'h00);
        tick();
        // R11 disable the latched bit
        drive(5'b00000, 0, 1, 8'h00);
        tick();
        drive(5'b00000, 0, 0, 8'h00);
        chk(irq_n === 1'b1, "R11 irq released on disable", {7'd0, irq_n}, 8'h01);
        chk(rd_data === 8'h00, "R11 live level", rd_data, 8'h00);
        tick();
        // R10 rise in the write cycle uses old (disabled) enable
        drive(5'b10000, 0, 1, 8'h80);
        tick();
        drive(5'b10000, 0, 0, 8'h00);
        chk(irq_n === 1'b1, "R10 rise during write ignored", {7'd0, irq_n}, 8'h01);
        chk(rd_data === 8'h00, "R10 enabled bit reads latch", rd_data, 8'h00);
        tick();
        // mixed patterns against the model
        for (int k = 0; k < 300; k++) begin
            logic [4:0] s;
            s = 5'((k * 7 + k / 3) ^ (k >> 2));
            drive(s, (k % 5) == 0, (k % 37) == 0, 8'((k * 29) ^ 8'h5A));
            tick();
        end
        done_flag = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R9 actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule